// File: doc/BRIEF.md
# Prescaled Up/Down Reload Timer

This block is a 16-bit timer driven through a programmable clock prescaler. A 10-bit prescaler counter produces one advance pulse every N clock cycles, with N anywhere from 1 to 1024. On each pulse the timer steps by one, either up or down according to a direction bit. When it runs past its end value it loads a 16-bit reload value and raises an overflow flag, which can request an interrupt. An 8-bit counting mode confines the count to its low byte.

Software reaches every setting through a small byte-wide register bus with address, write enable, read enable and data. Sixteen-bit values cross this bus through shadow bytes so that each 16-bit transfer is coherent. Reading a low byte freezes the matching high byte for a later read. A high-byte write is held back until the low-byte write that completes it. Software may also flip the direction or rewrite the count while the timer runs.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the count and reload value are 0, the prescale value is 0x3FF, the control byte (address 6) is 0, the overflow flag is 0 and `irq` is low.
- R2: With the run bit set and prescale value P (bits 7:0 at address 4, bits 1:0 of address 5), the count advances exactly once every 1024−P clock cycles.
- R3: Counting up in 16-bit mode, the count increments by one per advance. An advance from 0xFFFF loads the reload value (written low byte at address 2, high byte at address 3) and sets the overflow flag (address 7, bit 0).
- R4: Counting down (control bit 1 = 1), the count decrements by one per advance. An advance from zero loads the reload value and sets the overflow flag.
- R5: Changing the direction bit while running reverses the count sequence from the current value without a stop or a reload.
- R6: With control bit 2 set (8-bit mode), the end value is 0xFF going up and 0x00 going down. The reload uses only the low byte of the reload value, and the count's high byte reads 0 after every advance.
- R7: `irq` is high exactly when the overflow flag and the interrupt enable (control bit 3) are both set.
- R8: Writing 1 to address 7 bit 0 clears the overflow flag. Writing 0 there leaves it unchanged.
- R9: Reading the count low byte (address 0) or the reload low byte (address 2) latches the matching high byte. A read of address 1 or 3 returns that latched byte even if the live value has moved since.
- R10: A write to address 1 or 3 changes no visible value. The next write to address 0 or 2 loads the whole 16-bit count or reload, taking its high byte from the last high-byte write.
- R11: With the run bit (control bit 0) clear, the count holds its value.
- R12: A count write made while the timer is running takes effect at once and overrides an advance due in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; updates the read shadow |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The count is driven through an up-run across 0xFFFF at a prescale of 4, a down-run across zero at a prescale of 1, a direction flip in mid-run and an 8-bit run across 0xFF. These runs separate the step direction, the wrap detection and the reload width. Split 16-bit reads are timed so that the live count moves between the low and high accesses, which shows whether the shadow byte or the live byte is returned. A count write lands on a cycle that also carries an advance, which shows which of the two has priority. A long random mix of register writes and reads is then compared with a cycle-level bench model.

// File: rtl/prt_pkg.sv
package prt_pkg;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 10;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_LO = 3'd0,
        RA_CNT_HI = 3'd1,
        RA_RLD_LO = 3'd2,
        RA_RLD_HI = 3'd3,
        RA_PRE_LO = 3'd4,
        RA_PRE_HI = 3'd5,
        RA_CTRL   = 3'd6,
        RA_STAT   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic irq_en;
        logic narrow;
        logic down;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler
    import prt_pkg::*;
#(
    parameter int P_W = PRE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [P_W-1:0] reload,
    output logic           tick
);
    localparam logic [P_W-1:0] P_MAX = '1;

    typedef struct packed {
        logic [P_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.cnt == P_MAX);
        if (!run || tick) begin
            s_d.cnt = reload;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: P_MAX};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/prt_counter.sv
module prt_counter
    import prt_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int N_W = BUS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           down,
    input  logic           narrow,
    input  logic [C_W-1:0] reload,
    input  logic           wr_en,
    input  logic [C_W-1:0] wr_val,
    output logic [C_W-1:0] cnt,
    output logic           wrap
);
    localparam int HI_W = C_W - N_W;

    typedef struct packed {
        logic [C_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    logic           hit;
    logic [C_W-1:0] step;
    logic [C_W-1:0] rl;
    logic [N_W-1:0] lo_step;

    always_comb begin
        s_d     = s_q;
        lo_step = down ? (s_q.cnt[N_W-1:0] - 1'b1) : (s_q.cnt[N_W-1:0] + 1'b1);
        if (narrow) begin
            hit  = down ? ~|s_q.cnt[N_W-1:0] : &s_q.cnt[N_W-1:0];
            step = {{HI_W{1'b0}}, lo_step};
            rl   = {{HI_W{1'b0}}, reload[N_W-1:0]};
        end else begin
            hit  = down ? ~|s_q.cnt : &s_q.cnt;
            step = down ? (s_q.cnt - 1'b1) : (s_q.cnt + 1'b1);
            rl   = reload;
        end
        wrap = tick && hit && !wr_en;
        if (wr_en) begin
            s_d.cnt = wr_val;
        end else if (tick) begin
            s_d.cnt = hit ? rl : step;
        end
        cnt = s_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/prt_regs.sv
module prt_regs
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wval,
    output logic [CNT_W-1:0]  reload,
    output logic [PRE_W-1:0]  pre_reload,
    output ctrl_t             ctrl,
    output logic              flag
);
    localparam int PH_W = PRE_W - BUS_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  rld;
        logic [PRE_W-1:0]  pre;
        logic              flag;
        logic [BUS_W-1:0]  wsh;
        logic [BUS_W-1:0]  rsh;
    } reg_state_t;

    reg_state_t s_d, s_q;
    reg_addr_e  ra;
    logic       clr;

    always_comb begin
        s_d      = s_q;
        ra       = reg_addr_e'(bus_addr);
        cnt_wr   = bus_we && (ra == RA_CNT_LO);
        cnt_wval = {s_q.wsh, bus_wdata};
        clr      = bus_we && (ra == RA_STAT) && bus_wdata[0];

        if (bus_we) begin
            unique case (ra)
                RA_CNT_HI, RA_RLD_HI: s_d.wsh = bus_wdata;
                RA_RLD_LO: s_d.rld = {s_q.wsh, bus_wdata};
                RA_PRE_LO: s_d.pre[BUS_W-1:0] = bus_wdata;
                RA_PRE_HI: s_d.pre[PRE_W-1:BUS_W] = bus_wdata[PH_W-1:0];
                RA_CTRL:   s_d.ctrl = ctrl_t'(bus_wdata[3:0]);
                default: ;
            endcase
        end

        if (bus_re) begin
            if (ra == RA_CNT_LO) s_d.rsh = cnt[CNT_W-1:BUS_W];
            else if (ra == RA_RLD_LO) s_d.rsh = s_q.rld[CNT_W-1:BUS_W];
        end

        s_d.flag = wrap || (s_q.flag && !clr);

        unique case (ra)
            RA_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
            RA_RLD_LO: bus_rdata = s_q.rld[BUS_W-1:0];
            RA_CNT_HI, RA_RLD_HI: bus_rdata = s_q.rsh;
            RA_PRE_LO: bus_rdata = s_q.pre[BUS_W-1:0];
            RA_PRE_HI: bus_rdata = {{(BUS_W-PH_W){1'b0}}, s_q.pre[PRE_W-1:BUS_W]};
            RA_CTRL:   bus_rdata = {4'b0000, s_q.ctrl};
            RA_STAT:   bus_rdata = {{(BUS_W-1){1'b0}}, s_q.flag};
            default:   bus_rdata = '0;
        endcase

        reload     = s_q.rld;
        pre_reload = s_q.pre;
        ctrl       = s_q.ctrl;
        flag       = s_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.pre  <= '1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic             tick;
    logic             wrap;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wval;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;
    logic [PRE_W-1:0] pre_reload;
    ctrl_t            ctrl;
    logic             flag;
    logic             run, down, narrow, irq_en;

    assign run    = ctrl.run;
    assign down   = ctrl.down;
    assign narrow = ctrl.narrow;
    assign irq_en = ctrl.irq_en;

    prt_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt_q), .wrap(wrap),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
        .reload(reload), .pre_reload(pre_reload),
        .ctrl(ctrl), .flag(flag)
    );

    prt_prescaler #(.P_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run),
        .reload(pre_reload), .tick(tick)
    );

    prt_counter #(.C_W(CNT_W), .N_W(BUS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .down(down), .narrow(narrow), .reload(reload),
        .wr_en(cnt_wr), .wr_val(cnt_wval),
        .cnt(cnt_q), .wrap(wrap)
    );

    assign irq = flag & irq_en;
endmodule

// File: rtl/prt_checker.sv
module prt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        run,
    input logic        down,
    input logic        narrow,
    input logic        irq_en,
    input logic        cnt_wr,
    input logic [15:0] cnt,
    input logic        flag,
    input logic        irq
);
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> (cnt == $past(cnt))); // R11

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down && !narrow && !cnt_wr && cnt != 16'hFFFF) |=> (cnt == $past(cnt) + 16'd1)); // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down && !narrow && !cnt_wr && cnt != 16'h0000) |=> (cnt == $past(cnt) - 16'd1)); // R4

    AST_UP_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down && !narrow && !cnt_wr && cnt == 16'hFFFF) |=> flag); // R3

    AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && narrow && !cnt_wr) |=> (cnt[15:8] == 8'h00)); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R7

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R7

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R2
endmodule

bind prescaled_reload_timer prt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .down(down),
    .narrow(narrow), .irq_en(irq_en), .cnt_wr(cnt_wr), .cnt(cnt_q),
    .flag(flag), .irq(irq)
);

// File: tb/prescaled_reload_timer_test.sv
`timescale 1ns/1ps
module prescaled_reload_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prescaled_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model built from the requirements
    logic [15:0] m_cnt, m_rld;
    logic [9:0]  m_pre, m_pcnt;
    logic        m_run, m_dn, m_nar, m_en, m_flag;
    logic [7:0]  m_wsh, m_rsh;

    always @(posedge clk) begin
        logic tk, hit, wr_cnt, wrp;
        logic [15:0] nc;
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_pre = 10'h3FF; m_pcnt = 10'h3FF;
            m_run = 0; m_dn = 0; m_nar = 0; m_en = 0; m_flag = 0;
            m_wsh = 0; m_rsh = 0;
        end else begin
            tk = m_run && (m_pcnt == 10'h3FF);
            if (m_nar) hit = m_dn ? (m_cnt[7:0] == 8'h00) : (m_cnt[7:0] == 8'hFF);
            else       hit = m_dn ? (m_cnt == 16'h0000) : (m_cnt == 16'hFFFF);
            wr_cnt = bus_we && bus_addr == 3'd0;
            wrp = tk && hit && !wr_cnt;
            nc = m_cnt;
            if (tk) begin
                if (hit) nc = m_nar ? {8'h00, m_rld[7:0]} : m_rld;
                else if (m_nar) nc = {8'h00, m_dn ? m_cnt[7:0] - 8'd1 : m_cnt[7:0] + 8'd1};
                else nc = m_dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
            end
            if (wr_cnt) nc = {m_wsh, bus_wdata};
            m_pcnt = (!m_run || tk) ? m_pre : m_pcnt + 10'd1;
            if (bus_re && bus_addr == 3'd0) m_rsh = m_cnt[15:8];
            if (bus_re && bus_addr == 3'd2) m_rsh = m_rld[15:8];
            m_flag = wrp || (m_flag && !(bus_we && bus_addr == 3'd7 && bus_wdata[0]));
            if (bus_we) begin
                case (bus_addr)
                    3'd1, 3'd3: m_wsh = bus_wdata;
                    3'd2: m_rld = {m_wsh, bus_wdata};
                    3'd4: m_pre[7:0] = bus_wdata;
                    3'd5: m_pre[9:8] = bus_wdata[1:0];
                    3'd6: {m_en, m_nar, m_dn, m_run} = bus_wdata[3:0];
                    default: ;
                endcase
            end
            m_cnt = nc;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt[7:0];
            3'd1, 3'd3: return m_rsh;
            3'd2: return m_rld[7:0];
            3'd4: return m_pre[7:0];
            3'd5: return {6'b0, m_pre[9:8]};
            3'd6: return {4'b0, m_en, m_nar, m_dn, m_run};
            default: return {7'b0, m_flag};
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_re = 1'b0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 1'b0; bus_re = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, input string tag, output logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        chk({8'h00, bus_rdata}, {8'h00, exp_rd(a)}, tag);
        chk({15'b0, irq}, {15'b0, m_flag && m_en}, {tag, " irq R7"});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, prev;
        int last_chg, per;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset", v);
        rd(3'd4, "R1 pre lo", v); chk({8'h0, v}, 16'h00FF, "R1 pre lo const");
        rd(3'd5, "R1 pre hi", v); chk({8'h0, v}, 16'h0003, "R1 pre hi const");

        // R10 deferred high-byte write
        wr(3'd1, 8'h12);
        rd(3'd0, "R10 lo after hi write", v); chk({8'h0, v}, 16'h0000, "R10 no effect");
        wr(3'd0, 8'h34);
        rd(3'd0, "R10 lo", v); chk({8'h0, v}, 16'h0034, "R10 lo const");
        rd(3'd1, "R10 hi", v); chk({8'h0, v}, 16'h0012, "R10 hi const");

        // R11 stopped hold
        idle(20);
        rd(3'd0, "R11 hold", v); chk({8'h0, v}, 16'h0034, "R11 hold const");

        // R3 / R2 up-count across 0xFFFF at ratio 4
        wr(3'd3, 8'hAB); wr(3'd2, 8'hCD);
        wr(3'd1, 8'hFF); wr(3'd0, 8'hFD);
        wr(3'd5, 8'h03); wr(3'd4, 8'hFC);
        wr(3'd6, 8'h09);
        rd(3'd0, "R2 start", prev);
        last_chg = -1; per = 0;
        for (int i = 0; i < 40; i++) begin
            rd(3'd0, "R3 up run", v);
            if (v != prev) begin
                if (last_chg >= 0) chk(16'(i - last_chg), 16'd4, "R2 period");
                last_chg = i;
            end
            prev = v;
        end
        rd(3'd7, "R3 flag", v); chk({8'h0, v}, 16'h0001, "R3 flag const");
        rd(3'd2, "R3 rld lo", v);
        rd(3'd3, "R3 rld hi", v); chk({8'h0, v}, 16'h00AB, "R9 rld hi shadow");

        // R7 enable gating
        wr(3'd6, 8'h01);
        rd(3'd7, "R7 disabled", v); chk({15'b0, irq}, 16'h0000, "R7 irq off");

        // R8 write-one-to-clear
        wr(3'd7, 8'h00);
        rd(3'd7, "R8 zero write", v); chk({8'h0, v}, 16'h0001, "R8 keep");
        wr(3'd7, 8'h01);
        rd(3'd7, "R8 clear", v); chk({8'h0, v}, 16'h0000, "R8 cleared");

        // R4 down-count across zero at ratio 1
        wr(3'd1, 8'h00); wr(3'd0, 8'h03);
        wr(3'd5, 8'h03); wr(3'd4, 8'hFF);
        wr(3'd6, 8'h0B);
        for (int i = 0; i < 10; i++) rd(3'd0, "R4 down run", v);
        rd(3'd7, "R4 flag", v); chk({8'h0, v}, 16'h0001, "R4 flag const");

        // R5 reversal in mid-run
        wr(3'd6, 8'h09);
        rd(3'd0, "R5 after flip", prev);
        for (int i = 0; i < 6; i++) begin
            rd(3'd0, "R5 up again", v);
            chk({8'h0, v}, {8'h0, prev + 8'd1}, "R5 step up");
            prev = v;
        end

        // R6 narrow mode across 0xFF
        wr(3'd6, 8'h0D);
        for (int i = 0; i < 300; i++) rd(3'd0, "R6 narrow run", v);
        rd(3'd0, "R6 lo", v);
        rd(3'd1, "R6 hi", v); chk({8'h0, v}, 16'h0000, "R6 hi zero");

        // R12 write while running overrides the advance
        wr(3'd6, 8'h09);
        wr(3'd1, 8'h55); wr(3'd0, 8'h66);
        rd(3'd0, "R12 lo", v); chk({8'h0, v}, 16'h0066, "R12 lo const");
        rd(3'd1, "R12 hi", v); chk({8'h0, v}, 16'h0055, "R12 hi const");

        // R9 coherent split read while the count crosses a byte boundary
        wr(3'd1, 8'h12); wr(3'd0, 8'hFF);
        rd(3'd0, "R9 lo", v); chk({8'h0, v}, 16'h00FF, "R9 lo const");
        rd(3'd1, "R9 hi", v); chk({8'h0, v}, 16'h0012, "R9 hi shadow");
        rd(3'd0, "R9 moved", v);

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            if (a == 3'd5) d = 8'h03;
            if ($urandom_range(0, 9) < 3) wr(a, d);
            else rd(a, "R3 random", v);
        end
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule